// File: doc/BRIEF.md
# CRC Hamming Distance Evaluator

This engine measures how strongly a CRC generator polynomial of width k (2 to 16) detects errors. It relies on the linearity of the CRC. Contents and seed play no part, so the engine works on error positions alone. For each flipped data bit it keeps a k-bit syndrome. A pattern of d flipped data bits, with the XOR of their syndromes having w set bits, is an undetected error of total weight d + w. The weight counts the d data flips plus the w matching flips inside the check field.

Software or a test controller supplies the polynomial, k, a dataword length limit and a target distance, then pulses `start`. The engine grows the dataword one bit at a time. At each length it walks every new 1-, 2- and 3-bit error combination, one combination per clock. It stops at the first length that breaks the target and reports the last good length along with the offending pattern. If no pattern breaks the target up to the limit, it reports the limit as saturated.

Top module: `crc_hd_eval`

## Requirements
- R1: The generator is x^k + (sum of poly[i]·x^(i+1) for i < k-1) + 1. Bit k-1 of `poly` stands for x^k and is always taken as present. Bits k and above are ignored. k is taken from `crc_width` and must be 2..16.
- R2: While idle, a high `start` at a clock edge latches poly, crc_width, len_limit and target_hd. `busy` is high from the next cycle until the run ends. `done` is a single-cycle pulse that coincides with `busy` falling. The results hold until the next accepted start.
- R3: A `start` seen while `busy` is high is ignored. The running evaluation and its results are those of the original request.
- R4: Data position j counts from 0 at the bit next to the check field. Its syndrome is x^(j+k) mod G. A pattern of d data flips violates the target when d + popcount(XOR of the d syndromes) < target_hd.
- R5: Length L grows from 1. At each L only the combinations that contain position L-1 as their highest position are checked, in this order: the single bit; then pairs (i, L-1) with i ascending; then triples (i, j, L-1) in ascending (i, j) order. Level d is walked only when d < target_hd. The first violation ends the run with `violation`=1 and `max_len`=L-1. A violation wins over the length limit in the same cycle.
- R6: On a violation: `err_count`=d and `err_hi`=L-1. `err_mid` holds i for d=2 or j for d=3, and `err_lo` holds i for d=3. Unused position fields read 0. `err_syndrome` holds the XOR syndrome.
- R7: If no violation occurs up to the limit, `saturated`=1, `violation`=0, `max_len`=limit, and the error fields read 0. A `len_limit` of 0 or above MAX_LEN (64) means MAX_LEN.
- R8: A target of 2 or less never yields a violation and always saturates, since every single-bit syndrome is nonzero.
- R9: Each length costs one cycle plus one cycle for each checked combination. With target 2, a limit of N keeps `busy` high for 2N cycles; with target 1, for N cycles.
- R10: 0x968B (k=16) holds distance 5 through at least 19 data bits, and 0x5D7 (k=11) holds distance 5 through at least 26 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a run (sampled while idle) |
| poly | input | 16 | Generator in implicit +1 form |
| crc_width | input | 5 | CRC width k |
| len_limit | input | 7 | Longest dataword to evaluate |
| target_hd | input | 5 | Hamming distance to test |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| max_len | output | 7 | Largest length meeting the target |
| saturated | output | 1 | Limit reached without a violation |
| violation | output | 1 | A breaking pattern was found |
| err_count | output | 2 | Data bits flipped in the breaking pattern |
| err_hi | output | 6 | Highest flipped position |
| err_mid | output | 6 | Middle flipped position |
| err_lo | output | 6 | Lowest flipped position |
| err_syndrome | output | 16 | XOR syndrome of the breaking pattern |

## Verification
Two decisions can fall on the same clock: a violation found on the last combination of a length, and that length reaching the limit. The bench provokes this with x^8+1, target 3 and a limit of 1. The only combination, the single flip of bit 0, both ends the allowed length and breaks the target. The outcome is judged correct only if `violation` wins, with `max_len`=0 and `saturated` low. A second overlap, a new `start` arriving during a run, is judged by comparing every result field with the independent model of the original request.

// File: rtl/crc_hd_pkg.sv
package crc_hd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GROW  = 2'd1,
    ST_CHECK = 2'd2
  } eval_st_e;

  // number of set bits in a word
  function automatic logic [7:0] weight_of(input logic [31:0] v);
    logic [7:0] c;
    c = '0;
    for (int b = 0; b < 32; b++) c = c + {7'b0, v[b]};
    return c;
  endfunction

endpackage

// File: rtl/crc_hd_synd_step.sv
// One step of x-multiplication modulo the generator, or the first syndrome.
module crc_hd_synd_step #(
  parameter int KMAX = 16
) (
  input  logic [KMAX-1:0] poly,
  input  logic [4:0]      width,
  input  logic [KMAX-1:0] prev,
  input  logic            first,
  output logic [KMAX-1:0] nxt
);
  logic [KMAX-1:0] mask;
  logic [KMAX-1:0] low;
  logic            msb;
  logic            unused_poly_top;

  assign unused_poly_top = poly[KMAX-1];

  always_comb begin
    mask = '0;
    msb  = 1'b0;
    for (int b = 0; b < KMAX; b++) begin
      mask[b] = (b < int'(width));
      if (b == int'(width) - 1) msb = prev[b];
    end
    // x^k mod G: the generator without its leading term
    low = {poly[KMAX-2:0], 1'b1} & mask;
    if (first) nxt = low;
    else       nxt = ({prev[KMAX-2:0], 1'b0} & mask) ^ (msb ? low : '0);
  end

endmodule

// File: rtl/crc_hd_synd_store.sv
// Syndrome per data position, one write and three read ports.
module crc_hd_synd_store #(
  parameter int DEPTH = 64,
  parameter int KMAX  = 16,
  parameter int PW    = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [KMAX-1:0] wdata,
  input  logic [PW-1:0]   ra0,
  input  logic [PW-1:0]   ra1,
  input  logic [PW-1:0]   ra2,
  output logic [KMAX-1:0] rd0,
  output logic [KMAX-1:0] rd1,
  output logic [KMAX-1:0] rd2
);
  logic [KMAX-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];

endmodule

// File: rtl/crc_hd_combo_walk.sv
// Walks the combinations whose highest position is 'top'.
module crc_hd_combo_walk #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [PW-1:0] top,
  input  logic [4:0]    target,
  output logic [1:0]    lvl,
  output logic [PW-1:0] idx_i,
  output logic [PW-1:0] idx_j,
  output logic          last
);
  logic [1:0]    lvl_d;
  logic [PW-1:0] i_d, j_d;
  logic [PW-1:0] top_m1, top_m2;
  logic          lvl2_ok, lvl3_ok, walk_en;

  assign top_m1  = top - PW'(1);
  assign top_m2  = top - PW'(2);
  assign lvl2_ok = (target > 5'd2) && (top != '0);
  assign lvl3_ok = (target > 5'd3) && (top > PW'(1));
  assign walk_en = clear | advance;

  always_comb begin
    case (lvl)
      2'd2:    last = (idx_i == top_m1) && !lvl3_ok;
      2'd3:    last = (idx_i == top_m2) && (idx_j == top_m1);
      default: last = !lvl2_ok;
    endcase
  end

  always_comb begin
    lvl_d = lvl;
    i_d   = idx_i;
    j_d   = idx_j;
    if (clear) begin
      lvl_d = 2'd1;
      i_d   = '0;
      j_d   = '0;
    end else if (advance && !last) begin
      case (lvl)
        2'd1: begin
          lvl_d = 2'd2;
          i_d   = '0;
        end
        2'd2: begin
          if (idx_i != top_m1) i_d = idx_i + PW'(1);
          else begin
            lvl_d = 2'd3;
            i_d   = '0;
            j_d   = PW'(1);
          end
        end
        default: begin
          if (idx_j != top_m1) j_d = idx_j + PW'(1);
          else begin
            i_d = idx_i + PW'(1);
            j_d = idx_i + PW'(2);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 2'd1;
      idx_i <= '0;
      idx_j <= '0;
    end else if (walk_en) begin
      lvl   <= lvl_d;
      idx_i <= i_d;
      idx_j <= j_d;
    end
  end

  AST_TRIPLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd3) |-> ((idx_i < idx_j) && (idx_j < top))); // R5
  AST_PAIR_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd2) |-> (idx_i < top)); // R5

endmodule

// File: rtl/crc_hd_eval.sv
module crc_hd_eval
  import crc_hd_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int KMAX    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [KMAX-1:0]                    poly,
  input  logic [4:0]                         crc_width,
  input  logic [$clog2(MAX_LEN+1)-1:0]       len_limit,
  input  logic [4:0]                         target_hd,
  output logic                               busy,
  output logic                               done,
  output logic [$clog2(MAX_LEN+1)-1:0]       max_len,
  output logic                               saturated,
  output logic                               violation,
  output logic [1:0]                         err_count,
  output logic [$clog2(MAX_LEN)-1:0]         err_hi,
  output logic [$clog2(MAX_LEN)-1:0]         err_mid,
  output logic [$clog2(MAX_LEN)-1:0]         err_lo,
  output logic [KMAX-1:0]                    err_syndrome
);
  localparam int PW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  eval_st_e        st_q, st_d;
  logic [PW-1:0]   p_q, p_d;
  logic            p_en;
  logic [KMAX-1:0] prev_q, poly_q;
  logic [4:0]      width_q, tgt_q;
  logic [LW-1:0]   lim_q, lim_in_eff, len_now;
  logic            load;

  logic            done_d, sat_d, viol_d, res_en;
  logic [LW-1:0]   len_d;
  logic [1:0]      cnt_d;
  logic [PW-1:0]   hi_d, mid_d, lo_d;
  logic [KMAX-1:0] syn_d;

  logic [KMAX-1:0] syn_new, rd_top, rd_i, rd_j, combo_syn;
  logic [7:0]      combo_wt;
  logic            combo_bad, we;
  logic [1:0]      lvl;
  logic [PW-1:0]   wi, wj;
  logic            w_last, walk_clear, walk_adv;

  crc_hd_synd_step #(.KMAX(KMAX)) i_step (
    .poly  (poly_q),
    .width (width_q),
    .prev  (prev_q),
    .first (p_q == '0),
    .nxt   (syn_new)
  );

  crc_hd_synd_store #(.DEPTH(MAX_LEN), .KMAX(KMAX), .PW(PW)) i_store (
    .clk   (clk),
    .we    (we),
    .waddr (p_q),
    .wdata (syn_new),
    .ra0   (p_q),
    .ra1   (wi),
    .ra2   (wj),
    .rd0   (rd_top),
    .rd1   (rd_i),
    .rd2   (rd_j)
  );

  crc_hd_combo_walk #(.PW(PW)) i_walk (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (walk_clear),
    .advance (walk_adv),
    .top     (p_q),
    .target  (tgt_q),
    .lvl     (lvl),
    .idx_i   (wi),
    .idx_j   (wj),
    .last    (w_last)
  );

  assign lim_in_eff = ((len_limit == '0) || (len_limit > LW'(MAX_LEN))) ? LW'(MAX_LEN) : len_limit;
  assign len_now    = LW'(p_q) + LW'(1);
  assign combo_syn  = rd_top ^ ((lvl >= 2'd2) ? rd_i : '0) ^ ((lvl == 2'd3) ? rd_j : '0);
  assign combo_wt   = 8'(lvl) + weight_of(32'(combo_syn));
  assign combo_bad  = combo_wt < {3'b000, tgt_q};
  assign load       = (st_q == ST_IDLE) && start;
  assign res_en     = load | done_d;

  always_comb begin
    st_d       = st_q;
    p_d        = p_q;
    p_en       = 1'b0;
    we         = 1'b0;
    walk_clear = 1'b0;
    walk_adv   = 1'b0;
    done_d     = 1'b0;
    len_d      = max_len;
    sat_d      = saturated;
    viol_d     = violation;
    cnt_d      = err_count;
    hi_d       = err_hi;
    mid_d      = err_mid;
    lo_d       = err_lo;
    syn_d      = err_syndrome;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d       = ST_GROW;
          p_d        = '0;
          p_en       = 1'b1;
          walk_clear = 1'b1;
          len_d      = '0;
          sat_d      = 1'b0;
          viol_d     = 1'b0;
          cnt_d      = '0;
          hi_d       = '0;
          mid_d      = '0;
          lo_d       = '0;
          syn_d      = '0;
        end
      end
      ST_GROW: begin
        we         = 1'b1;
        walk_clear = 1'b1;
        if (tgt_q <= 5'd1) begin
          if (len_now >= lim_q) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            sat_d  = 1'b1;
            len_d  = lim_q;
          end else begin
            p_d  = p_q + PW'(1);
            p_en = 1'b1;
          end
        end else begin
          st_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (combo_bad) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          viol_d = 1'b1;
          len_d  = LW'(p_q);
          cnt_d  = lvl;
          hi_d   = p_q;
          mid_d  = (lvl == 2'd2) ? wi : ((lvl == 2'd3) ? wj : '0);
          lo_d   = (lvl == 2'd3) ? wi : '0;
          syn_d  = combo_syn;
        end else if (w_last) begin
          if (len_now >= lim_q) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            sat_d  = 1'b1;
            len_d  = lim_q;
          end else begin
            st_d = ST_GROW;
            p_d  = p_q + PW'(1);
            p_en = 1'b1;
          end
        end else begin
          walk_adv = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q         <= ST_IDLE;
      p_q          <= '0;
      prev_q       <= '0;
      poly_q       <= '0;
      width_q      <= '0;
      tgt_q        <= '0;
      lim_q        <= '0;
      done         <= 1'b0;
      max_len      <= '0;
      saturated    <= 1'b0;
      violation    <= 1'b0;
      err_count    <= '0;
      err_hi       <= '0;
      err_mid      <= '0;
      err_lo       <= '0;
      err_syndrome <= '0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (p_en) p_q <= p_d;
      if (we) prev_q <= syn_new;
      if (load) begin
        poly_q  <= poly;
        width_q <= crc_width;
        tgt_q   <= target_hd;
        lim_q   <= lim_in_eff;
      end
      if (res_en) begin
        max_len      <= len_d;
        saturated    <= sat_d;
        violation    <= viol_d;
        err_count    <= cnt_d;
        err_hi       <= hi_d;
        err_mid      <= mid_d;
        err_lo       <= lo_d;
        err_syndrome <= syn_d;
      end
    end
  end

  assign busy = (st_q != ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done); // R2
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && start) |=> busy); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && start) |=> ($stable(poly_q) && $stable(width_q) && $stable(tgt_q) && $stable(lim_q))); // R3
  AST_VIOL_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && violation) |-> ((8'(err_count) + weight_of(32'(err_syndrome))) < {3'b000, tgt_q})); // R4
  AST_SAT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> !(saturated && violation)); // R7
  AST_SAT_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && saturated) |-> (max_len == lim_q)); // R7
  AST_SINGLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((st_q == ST_CHECK) && (lvl == 2'd1)) |-> (rd_top != '0)); // R8
  AST_LOW_TARGET_SATURATES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && (tgt_q <= 5'd2)) |-> saturated); // R8

endmodule

// File: tb/test_crc_hd_eval.sv
module test_crc_hd_eval;
  localparam int MAXL = 64;
  localparam int LW   = 7;
  localparam int PW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   poly = '0;
  logic [4:0]    crc_width = '0;
  logic [LW-1:0] len_limit = '0;
  logic [4:0]    target_hd = '0;
  logic          busy, done, saturated, violation;
  logic [LW-1:0] max_len;
  logic [1:0]    err_count;
  logic [PW-1:0] err_hi, err_mid, err_lo;
  logic [15:0]   err_syndrome;

  int checks = 0;
  int errors = 0;
  int r_len, r_sat, r_viol, r_d, r_hi, r_mid, r_lo, r_syn, r_cyc;
  int e_len, e_sat, e_viol, e_d, e_hi, e_mid, e_lo, e_syn;

  always #10 clk = ~clk;

  crc_hd_eval i_crc_hd_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .poly(poly), .crc_width(crc_width),
    .len_limit(len_limit), .target_hd(target_hd), .busy(busy), .done(done),
    .max_len(max_len), .saturated(saturated), .violation(violation),
    .err_count(err_count), .err_hi(err_hi), .err_mid(err_mid), .err_lo(err_lo),
    .err_syndrome(err_syndrome)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model: long division per position, walk in the stated order.
  task automatic model(input int p, input int k, input int lim, input int tgt);
    int full, r, w, le;
    int syn [MAXL];
    bit found;
    full  = (1 << k) | ((((p << 1) | 1)) & ((1 << k) - 1));
    le    = (lim == 0 || lim > MAXL) ? MAXL : lim;
    found = 0;
    e_len = le; e_sat = 1; e_viol = 0; e_d = 0; e_hi = 0; e_mid = 0; e_lo = 0; e_syn = 0;
    for (int t = 0; t < le && !found; t++) begin
      r = 1;
      for (int n = 0; n < t + k; n++) begin
        r = r << 1;
        if (((r >> k) & 1) == 1) r = r ^ full;
      end
      syn[t] = r;
      if (!found && tgt > 1) begin
        w = $countones(syn[t]);
        if (1 + w < tgt) begin
          found = 1; e_d = 1; e_hi = t; e_syn = syn[t];
        end
      end
      if (tgt > 2) for (int a = 0; a < t && !found; a++) begin
        w = $countones(syn[a] ^ syn[t]);
        if (2 + w < tgt) begin
          found = 1; e_d = 2; e_hi = t; e_mid = a; e_syn = syn[a] ^ syn[t];
        end
      end
      if (tgt > 3) for (int a = 0; a < t && !found; a++)
        for (int b = a + 1; b < t && !found; b++) begin
          w = $countones(syn[a] ^ syn[b] ^ syn[t]);
          if (3 + w < tgt) begin
            found = 1; e_d = 3; e_hi = t; e_mid = b; e_lo = a; e_syn = syn[a] ^ syn[b] ^ syn[t];
          end
        end
      if (found) begin
        e_len = t; e_sat = 0; e_viol = 1;
      end
    end
  endtask

  task automatic run(input logic [15:0] p, input int k, input int lim, input int tgt, input bit disturb);
    int guard;
    @(negedge clk);
    poly = p; crc_width = k[4:0]; len_limit = lim[LW-1:0]; target_hd = tgt[4:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_cyc = 0;
    guard = 0;
    while (!done) begin
      if (busy) r_cyc++;
      if (disturb && r_cyc == 10) begin
        start = 1'b1; poly = 16'h0009; crc_width = 5'd4; target_hd = 5'd3; len_limit = 7'd5;
      end else start = 1'b0;
      guard++;
      if (guard > 100000) begin
        checks++; errors++;
        $display("FAIL R2 watchdog: actual %0d expected done", guard);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    r_len = int'(max_len); r_sat = int'(saturated); r_viol = int'(violation);
    r_d = int'(err_count); r_hi = int'(err_hi); r_mid = int'(err_mid); r_lo = int'(err_lo);
    r_syn = int'(err_syndrome);
  endtask

  task automatic cmp_model(input string req);
    check(req, "max_len", r_len, e_len);
    check(req, "saturated", r_sat, e_sat);
    check(req, "violation", r_viol, e_viol);
    check(req, "err_count", r_d, e_d);
    check(req, "err_hi", r_hi, e_hi);
    check(req, "err_mid", r_mid, e_mid);
    check(req, "err_lo", r_lo, e_lo);
    check(req, "err_syndrome", r_syn, e_syn);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2", "busy after reset", int'(busy), 0);
    check("R2", "done after reset", int'(done), 0);
    check("R2", "violation after reset", int'(violation), 0);
    check("R2", "saturated after reset", int'(saturated), 0);
    check("R2", "max_len after reset", int'(max_len), 0);
  endtask

  task automatic t_primitive();
    run(16'h0009, 4, 64, 3, 0);
    check("R4", "primitive k4 max_len", r_len, 11);
    check("R5", "primitive k4 violation", r_viol, 1);
    check("R6", "primitive k4 d", r_d, 1);
    check("R6", "primitive k4 err_hi", r_hi, 11);
    check("R6", "primitive k4 syndrome", r_syn, 1);
    model(16'h0009, 4, 64, 3);
    cmp_model("R5");
  endtask

  task automatic t_high_bits();
    run(16'hFFF9, 4, 64, 3, 0);
    check("R1", "upper poly bits ignored max_len", r_len, 11);
    check("R1", "upper poly bits ignored syndrome", r_syn, 1);
  endtask

  task automatic t_low_target();
    run(16'h0009, 4, 64, 2, 0);
    check("R8", "target 2 saturated", r_sat, 1);
    check("R8", "target 2 violation", r_viol, 0);
    check("R8", "target 2 max_len", r_len, 64);
    check("R9", "target 2 busy cycles", r_cyc, 128);
    run(16'h0083, 8, 10, 1, 0);
    check("R9", "target 1 busy cycles", r_cyc, 10);
    check("R8", "target 1 max_len", r_len, 10);
  endtask

  task automatic t_zero_len();
    run(16'h0080, 8, 64, 3, 0);
    check("R5", "x^8+1 max_len", r_len, 0);
    check("R6", "x^8+1 err_hi", r_hi, 0);
    check("R6", "x^8+1 syndrome", r_syn, 1);
    // violation on the last combination at the limit: violation wins
    run(16'h0080, 8, 1, 3, 0);
    check("R5", "limit-edge violation", r_viol, 1);
    check("R7", "limit-edge saturated", r_sat, 0);
    check("R5", "limit-edge max_len", r_len, 0);
  endtask

  task automatic t_saturate();
    run(16'h0009, 4, 5, 3, 0);
    check("R7", "limit 5 saturated", r_sat, 1);
    check("R7", "limit 5 max_len", r_len, 5);
    check("R7", "limit 5 err_count", r_d, 0);
    check("R7", "limit 5 syndrome", r_syn, 0);
    run(16'h0009, 4, 0, 2, 0);
    check("R7", "limit 0 means max", r_len, 64);
    run(16'h0009, 4, 100, 2, 0);
    check("R7", "limit 100 clamps", r_len, 64);
  endtask

  task automatic t_references();
    run(16'h968B, 16, 40, 5, 0);
    check("R10", "0x968B holds 19", int'(r_len >= 19), 1);
    model(16'h968B, 16, 40, 5);
    cmp_model("R10");
    run(16'h05D7, 11, 40, 5, 0);
    check("R10", "0x5D7 holds 26", int'(r_len >= 26), 1);
    model(16'h05D7, 11, 40, 5);
    cmp_model("R10");
  endtask

  task automatic t_model_sweep();
    run(16'h000F, 4, 32, 4, 0);
    model(16'h000F, 4, 32, 4);
    cmp_model("R6");
    run(16'h8810, 16, 32, 4, 0);
    model(16'h8810, 16, 32, 4);
    cmp_model("R5");
    run(16'h0083, 8, 40, 4, 0);
    model(16'h0083, 8, 40, 4);
    cmp_model("R4");
  endtask

  task automatic t_busy_start();
    run(16'h05D7, 11, 40, 5, 1);
    model(16'h05D7, 11, 40, 5);
    cmp_model("R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_primitive();
    t_high_bits();
    t_low_target();
    t_zero_len();
    t_saturate();
    t_references();
    t_model_sweep();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule